// File: doc/BRIEF.md
# Fault Timer and Protection Sequencer

This block decides when a switching power controller may issue gate pulses. It watches four health flags: supply above the startup level, supply below the minimum operating level, loss of feedback regulation, and overvoltage. From them it runs three pieces of state. The first is a fault window timer. The second is a forced-off rest period eight windows long. The third is an overvoltage lock. Its outputs are a gate enable for the switching logic, an enable for the startup current source, and a flag that takes frequency control away from the oscillator while a fault is being timed.

Timing is counted in ticks of an internal prescaler, so one window lasts `WINDOW_TICKS * PRESCALE` clock cycles. If the feedback loop stays broken, the output follows a burst pattern: one window of pulses, then eight windows with no pulses, over and over. If the loop recovers during a rest period, the rest period ends early. Pulses then wait for the next time the supply climbs through its startup level. An overvoltage event stops all pulses. That lock clears only after the supply has fallen below its minimum level.

Every flag passes through a two-stage synchronizer before the block uses it. The feedback-loss flag is read through a hysteretic latch with separate set and clear inputs.

Top module: `prot_sequencer`

## Requirements
- R1: After reset, gate_enable and osc_release are 0 and startup_enable is 1. Gate pulses stay off until sup_hi_async is seen rising.
- R2: Once the fault latch is set while running, gate_enable stays 1 and osc_release stays 1 for exactly WINDOW_TICKS*PRESCALE cycles. Then both drop to 0.
- R3: After a fault window expires, gate_enable stays 0 for exactly 8*WINDOW_TICKS*PRESCALE cycles.
- R4: While the fault latch stays set, a new fault window begins as soon as the rest period ends, so the burst pattern repeats.
- R5: If the fault latch clears before the window ends, osc_release returns to 0 and the window count goes back to zero. The next fault gets a full window.
- R6: The fault latch is set by loop_low_async. It is cleared only when loop_ok_async is 1 and loop_low_async is 0. With both inputs at 0 it keeps its value.
- R7: If the fault latch clears during a rest period, the rest period ends. gate_enable stays 0 until the next rising edge of sup_hi_async, and then returns with osc_release at 0.
- R8: ovp_async forces gate_enable to 0 from any state. The lock holds after ovp_async falls, and it survives a startup-level rise that comes with no undervoltage. It clears only when sup_lo_async is seen. Pulses then resume on the next sup_hi_async rise.
- R9: sup_lo_async during normal running or a fault window forces gate_enable and osc_release to 0. Pulses return on the next sup_hi_async rise.
- R10: sup_lo_async sets startup_enable to 1 and sup_hi_async clears it. With both at 0 it keeps its value, so the startup source makes the supply hiccup during a rest period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_hi_async | input | 1 | Supply above startup threshold (asynchronous) |
| sup_lo_async | input | 1 | Supply below minimum operating level (asynchronous) |
| loop_low_async | input | 1 | Regulation node below fault threshold (asynchronous) |
| loop_ok_async | input | 1 | Regulation node back above threshold plus hysteresis (asynchronous) |
| ovp_async | input | 1 | Overvoltage comparator output (asynchronous) |
| gate_enable | output | 1 | Allows switching pulses |
| startup_enable | output | 1 | Turns on the startup current source |
| osc_release | output | 1 | Fault window active: the oscillator gives up frequency control |

## Verification
The assertions assume that the two supply flags are never both 1, since the supply cannot be above its startup level and below its minimum at once. They also assume that the two loop flags describe one analog node, so the clear flag only matters once the set flag has dropped. The bench drives the supply only through helper tasks that move it between the low, middle and high bands, which keeps the supply flags consistent. It changes the loop flags on falling clock edges and holds each level for several cycles, so the synchronizers always see clean values.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int unsigned OFF_MULT = 8;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_RUN    = 3'd1,
        ST_ARMED  = 3'd2,
        ST_REST   = 3'd3,
        ST_OVLOCK = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic sup_hi;
        logic sup_lo;
        logic loop_low;
        logic loop_ok;
        logic ovp;
    } flags_t;

    localparam int unsigned FLAG_W = $bits(flags_t);

    function automatic int unsigned rest_ticks(input int unsigned window);
        return OFF_MULT * window;
    endfunction

    function automatic logic pulses_allowed(input seq_state_t s);
        return (s == ST_RUN) || (s == ST_ARMED);
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/health_filter.sv
module health_filter
    import prot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flags,
    output logic   fault_q,
    output logic   startup_q,
    output logic   start_rise
);
    logic hi_prev_q;

    // Loop-fault latch with separate set and clear levels
    always_ff @(posedge clk) begin
        if (rst)                                  fault_q <= 1'b0;
        else if (flags.loop_low)                  fault_q <= 1'b1;
        else if (flags.loop_ok)                   fault_q <= 1'b0;
    end

    // Startup source: on at the low level, off at the startup level
    always_ff @(posedge clk) begin
        if (rst)               startup_q <= 1'b1;
        else if (flags.sup_lo) startup_q <= 1'b1;
        else if (flags.sup_hi) startup_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) hi_prev_q <= 1'b0;
        else     hi_prev_q <= flags.sup_hi;
    end

    assign start_rise = flags.sup_hi & ~hi_prev_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import prot_pkg::*;
#(
    parameter int unsigned PRESCALE     = 1000,
    parameter int unsigned WINDOW_TICKS = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic long_sel,
    output logic expire
);
    localparam int unsigned OFF_TICKS = rest_ticks(WINDOW_TICKS);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int unsigned UW = (OFF_TICKS > 1) ? $clog2(OFF_TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [UW-1:0] WIN_LAST = UW'(WINDOW_TICKS - 1);
    localparam logic [UW-1:0] OFF_LAST = UW'(OFF_TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [UW-1:0] unit_q;
    logic          tick;
    logic [UW-1:0] last_unit;

    assign tick      = run && (pre_q == PRE_LAST);
    assign last_unit = long_sel ? OFF_LAST : WIN_LAST;
    assign expire    = tick && (unit_q == last_unit);

    always_ff @(posedge clk) begin
        if (rst || clear) pre_q <= '0;
        else if (run)     pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) unit_q <= '0;
        else if (tick)    unit_q <= unit_q + 1'b1;
    end
endmodule

// File: rtl/prot_sequencer.sv
module prot_sequencer
    import prot_pkg::*;
#(
    parameter int unsigned PRESCALE     = 1000,
    parameter int unsigned WINDOW_TICKS = 128,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_hi_async,
    input  logic sup_lo_async,
    input  logic loop_low_async,
    input  logic loop_ok_async,
    input  logic ovp_async,
    output logic gate_enable,
    output logic startup_enable,
    output logic osc_release
);
    flags_t     raw_f, sync_f;
    seq_state_t state_q, state_d;
    logic       fault_q, startup_q, start_rise;
    logic       expire, timer_clear, timer_run;
    logic       sup_lo_s, loop_low_s, loop_ok_s;

    assign raw_f = '{sup_hi:   sup_hi_async,
                     sup_lo:   sup_lo_async,
                     loop_low: loop_low_async,
                     loop_ok:  loop_ok_async,
                     ovp:      ovp_async};

    flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_f),
        .q   (sync_f)
    );

    assign sup_lo_s   = sync_f.sup_lo;
    assign loop_low_s = sync_f.loop_low;
    assign loop_ok_s  = sync_f.loop_ok;

    health_filter u_filter (
        .clk        (clk),
        .rst        (rst),
        .flags      (sync_f),
        .fault_q    (fault_q),
        .startup_q  (startup_q),
        .start_rise (start_rise)
    );

    assign timer_run   = (state_q == ST_ARMED) || (state_q == ST_REST);
    assign timer_clear = (state_d != state_q);

    tick_timer #(.PRESCALE(PRESCALE), .WINDOW_TICKS(WINDOW_TICKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (timer_clear),
        .run      (timer_run),
        .long_sel (state_q == ST_REST),
        .expire   (expire)
    );

    always_comb begin
        state_d = state_q;
        if (sync_f.ovp && state_q != ST_OVLOCK) begin
            state_d = ST_OVLOCK;
        end else begin
            unique case (state_q)
                ST_WAIT:   if (start_rise) state_d = fault_q ? ST_ARMED : ST_RUN;
                ST_RUN: begin
                    if (sync_f.sup_lo)     state_d = ST_WAIT;
                    else if (fault_q)      state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (sync_f.sup_lo)     state_d = ST_WAIT;
                    else if (!fault_q)     state_d = ST_RUN;
                    else if (expire)       state_d = ST_REST;
                end
                ST_REST: begin
                    if (!fault_q)          state_d = ST_WAIT;
                    else if (expire)       state_d = ST_ARMED;
                end
                ST_OVLOCK: if (sync_f.sup_lo) state_d = ST_WAIT;
                default:                   state_d = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    assign gate_enable    = pulses_allowed(state_q);
    assign osc_release    = (state_q == ST_ARMED);
    assign startup_enable = startup_q;
endmodule

// File: rtl/prot_sequencer_chk.sv
module prot_sequencer_chk
    import prot_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       gate_enable,
    input logic       startup_enable,
    input logic       osc_release,
    input seq_state_t state_q,
    input logic       sup_lo_s,
    input logic       start_rise,
    input logic       fault_q,
    input logic       loop_low_s,
    input logic       loop_ok_s
);
    AST_WAKE_ON_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_enable) && $past(state_q) == ST_WAIT) |-> $past(start_rise)); // R7

    AST_REST_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate_enable) && state_q == ST_REST) |-> $past(osc_release)); // R2

    AST_OVLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVLOCK && !sup_lo_s) |=> (state_q == ST_OVLOCK)); // R8

    AST_STARTUP_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(startup_enable) |-> $past(sup_lo_s)); // R10

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> ($past(loop_ok_s) && !$past(loop_low_s))); // R6
endmodule

bind prot_sequencer prot_sequencer_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .gate_enable    (gate_enable),
    .startup_enable (startup_enable),
    .osc_release    (osc_release),
    .state_q        (state_q),
    .sup_lo_s       (sup_lo_s),
    .start_rise     (start_rise),
    .fault_q        (fault_q),
    .loop_low_s     (loop_low_s),
    .loop_ok_s      (loop_ok_s)
);

// File: tb/prot_sequencer_tb.sv
module prot_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 4;
    localparam int W   = 3;
    localparam int WIN = W * P;
    localparam int OFF = 8 * W * P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_hi = 1'b0, sup_lo = 1'b1, loop_low = 1'b0, loop_ok = 1'b1, ovp = 1'b0;
    logic gate_enable, startup_enable, osc_release;
    int   errors = 0, checks = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_sequencer #(.PRESCALE(P), .WINDOW_TICKS(W)) u_dut (
        .clk(clk), .rst(rst),
        .sup_hi_async(sup_hi), .sup_lo_async(sup_lo),
        .loop_low_async(loop_low), .loop_ok_async(loop_ok), .ovp_async(ovp),
        .gate_enable(gate_enable), .startup_enable(startup_enable),
        .osc_release(osc_release)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic supply_low();  sup_hi = 1'b0; sup_lo = 1'b1; endtask
    task automatic supply_mid();  sup_hi = 1'b0; sup_lo = 1'b0; endtask
    task automatic supply_high(); sup_hi = 1'b1; sup_lo = 1'b0; endtask
    task automatic loop_fault();  loop_low = 1'b1; loop_ok = 1'b0; endtask
    task automatic loop_good();   loop_low = 1'b0; loop_ok = 1'b1; endtask
    task automatic loop_band();   loop_low = 1'b0; loop_ok = 1'b0; endtask

    task automatic measure_release(output int n);
        int guard = 0;
        while (osc_release !== 1'b1 && guard < 60) begin guard++; @(negedge clk); end
        n = 0;
        while (osc_release === 1'b1 && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic measure_gate_low(output int n);
        n = 0;
        while (gate_enable === 1'b0 && n < 2000) begin n++; @(negedge clk); end
    endtask

    // Recover the loop and cycle the supply so pulses resume
    task automatic restart();
        loop_good(); cyc(6);
        supply_low(); cyc(6);
        supply_high(); cyc(6);
    endtask

    initial begin
        int n;
        cyc(3);
        check(gate_enable === 1'b0, "R1 gate after reset", gate_enable, 0);
        check(osc_release === 1'b0, "R1 release after reset", osc_release, 0);
        check(startup_enable === 1'b1, "R1 startup after reset", startup_enable, 1);
        rst = 1'b0;
        cyc(10);
        check(gate_enable === 1'b0, "R1 gate before startup level", gate_enable, 0);
        supply_high(); cyc(6);
        check(gate_enable === 1'b1, "R1 gate after startup rise", gate_enable, 1);
        check(startup_enable === 1'b0, "R10 startup off at startup level", startup_enable, 0);

        // Persistent fault: burst pattern
        loop_fault();
        measure_release(n);
        check(n == WIN, "R2 fault window length", n, WIN);
        check(gate_enable === 1'b0, "R2 gate off after window", gate_enable, 0);
        measure_gate_low(n);
        check(n == OFF, "R3 rest period length", n, OFF);
        check(osc_release === 1'b1 && gate_enable === 1'b1, "R4 new window after rest",
              {gate_enable, osc_release}, 3);
        measure_release(n);
        check(n == WIN, "R4 repeated window length", n, WIN);

        // Recovery during rest
        cyc(5);
        loop_good(); cyc(30);
        check(gate_enable === 1'b0, "R7 no resume without startup rise", gate_enable, 0);
        supply_low(); cyc(5);
        check(startup_enable === 1'b1, "R10 startup on at low level", startup_enable, 1);
        supply_mid(); cyc(5);
        check(startup_enable === 1'b1, "R10 startup holds in middle band", startup_enable, 1);
        supply_high(); cyc(6);
        check(gate_enable === 1'b1, "R7 resume on startup rise", gate_enable, 1);
        check(osc_release === 1'b0, "R7 release low after resume", osc_release, 0);
        check(startup_enable === 1'b0, "R10 startup off again", startup_enable, 0);

        // Short fault resets the timer
        loop_fault(); cyc(6);
        loop_good(); cyc(8);
        check(osc_release === 1'b0, "R5 release drops when fault clears", osc_release, 0);
        check(gate_enable === 1'b1, "R5 pulses continue", gate_enable, 1);
        loop_fault();
        measure_release(n);
        check(n == WIN, "R5 full window after early clear", n, WIN);
        restart();

        // Hysteresis: fault kept with both loop flags low
        loop_fault(); cyc(4);
        loop_band();
        measure_release(n);
        check(n == WIN, "R6 fault held in band", n, WIN);
        check(gate_enable === 1'b0, "R6 rest entered", gate_enable, 0);
        restart();
        check(gate_enable === 1'b1, "R6 recovered", gate_enable, 1);

        // Overvoltage lock
        ovp = 1'b1; cyc(3); ovp = 1'b0; cyc(5);
        check(gate_enable === 1'b0, "R8 overvoltage stops gate", gate_enable, 0);
        cyc(20);
        check(gate_enable === 1'b0, "R8 lock holds", gate_enable, 0);
        supply_mid(); cyc(5); supply_high(); cyc(8);
        check(gate_enable === 1'b0, "R8 lock survives rise without undervoltage", gate_enable, 0);
        supply_low(); cyc(5); supply_high(); cyc(6);
        check(gate_enable === 1'b1, "R8 lock cleared by undervoltage", gate_enable, 1);

        // Undervoltage during run and during a window
        supply_low(); cyc(5);
        check(gate_enable === 1'b0, "R9 undervoltage in run", gate_enable, 0);
        supply_high(); cyc(6);
        check(gate_enable === 1'b1, "R9 resume after undervoltage", gate_enable, 1);
        loop_fault(); cyc(6);
        check(osc_release === 1'b1, "R9 window running", osc_release, 1);
        supply_low(); cyc(5);
        check(gate_enable === 1'b0 && osc_release === 1'b0, "R9 undervoltage in window",
              {gate_enable, osc_release}, 0);
        loop_good(); cyc(5); supply_high(); cyc(6);
        check(gate_enable === 1'b1, "R9 resume after window undervoltage", gate_enable, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule